// File: doc/BRIEF.md
# External Interrupt Line Controller

The block watches 32 external interrupt pins, grouped into four banks of eight. Each pin passes through a synchronizer. A per-line trigger type then decides whether the pin sets that line's pending latch. The type can be a low or high level, or a falling, rising or either edge. Software acknowledges a line by writing a one to its pending bit. A per-line mask bit decides whether a pending line reaches an output.

Lines 0 to 15 each drive their own interrupt output. Lines 16 to 31 are merged onto one shared output. A service index goes with the shared output and names the line to handle first: the highest-numbered unmasked pending line in the 16–23 bank, or, if that bank is quiet, the highest one in the 24–31 bank. A simple single-cycle register bus gives access, for each bank, to its trigger-type word, its mask word and its pending word.

Top module: `eirq_ctrl`

## Requirements
- R1: After reset, every mask bit is 1 and every trigger field and pending bit is 0. The direct outputs, the shared output and the service index are all 0.
- R2: The word address is {bank[1:0], sel[1:0]}, where sel 0 selects the trigger-type word, sel 1 the mask word, sel 2 the pending word, and sel 3 reads as zero. Line k belongs to bank k/8, slot j = k mod 8. Its 3-bit trigger type sits at bits [4j+2:4j] of the type word, and bit 4j+3 reads 0. Mask and pending use bit j, and bits 31:8 of those words read 0.
- R3: Type 0 (low level) and type 1 (high level) keep the pending bit set on every cycle the synchronized level is active. A pin change becomes visible in pending on the third rising clock edge after it.
- R4: Type 2 sets pending on a falling transition, type 3 on a rising one and type 4 on either. The latch holds after the pin returns. Types 5, 6 and 7 never set pending.
- R5: Writing 1 to a pending-word bit clears that line. Writing 0 leaves it unchanged.
- R6: When a set event and a write-one clear hit the same line in the same cycle, the line stays pending.
- R7: A mask bit of 1 keeps its line off every output, but the pending bit still latches and reads back.
- R8: For k in 0..15, the direct output bit k is high exactly when line k is pending and unmasked.
- R9: The shared output is high exactly when any of lines 16..31 is pending and unmasked.
- R10: The service index is the highest unmasked pending line among 16..23. If there is none, it is the highest among 24..31. It reads 0 when the shared output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins | input | 32 | Raw external interrupt pins |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address {bank, sel} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_direct | output | 16 | Per-line outputs for lines 0..15 |
| irq_shared | output | 1 | Merged output for lines 16..31 |
| shared_line | output | 5 | Line number to service first on the shared output |

## Verification
The bench covers several failure modes:
- Clearing a high-level line while its pin is still high must leave it pending. A design where the clear beats the set would drop a live level.
- A falling-type line must ignore a rising pin, and types 5 to 7 must stay silent under toggling. A decoder that treats unused codes as an edge type would raise spurious interrupts.
- With lines 20, 22 and 30 pending together, the index must move from 22 to 30 only after the lower bank is cleared. A flat highest-wins search would report 30 straight away.
- A long random phase mixes pin noise with random type, mask and clear writes, and compares every output and readback against a cycle-level model, which also exposes an off-by-one synchronizer depth.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

   typedef enum logic [2:0] {
      TRIG_LVL_LO  = 3'd0,
      TRIG_LVL_HI  = 3'd1,
      TRIG_EDGE_FL = 3'd2,
      TRIG_EDGE_RS = 3'd3,
      TRIG_EDGE_AN = 3'd4
   } trig_e;

   localparam int TRIG_W  = 3;
   localparam int FIELD_W = 4;

   localparam logic [1:0] SEL_TYPE = 2'd0;
   localparam logic [1:0] SEL_MASK = 2'd1;
   localparam logic [1:0] SEL_PEND = 2'd2;

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad
         $error("eirq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], d};
   end

   assign q = sh_q[STAGES-1];

endmodule

// File: rtl/eirq_line.sv
module eirq_line
   import eirq_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin,
   input  logic [TRIG_W-1:0] trig,
   input  logic              clr,
   output logic              pend
);

   logic lvl;
   logic prev_q;
   logic set_evt;
   logic pend_q;

   eirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin),
      .q    (lvl)
   );

   always_comb begin
      case (trig_e'(trig))
         TRIG_LVL_LO:  set_evt = ~lvl;
         TRIG_LVL_HI:  set_evt = lvl;
         TRIG_EDGE_FL: set_evt = prev_q & ~lvl;
         TRIG_EDGE_RS: set_evt = ~prev_q & lvl;
         TRIG_EDGE_AN: set_evt = prev_q ^ lvl;
         default:      set_evt = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= lvl;
         pend_q <= set_evt | (pend_q & ~clr);
      end
   end

   assign pend = pend_q;

endmodule

// File: rtl/eirq_pick.sv
module eirq_pick #(
   parameter int GROUPS  = 2,
   parameter int GROUP_W = 8,
   parameter int BASE    = 16,
   parameter int IDX_W   = 5
) (
   input  logic [GROUPS*GROUP_W-1:0] req,
   output logic                      any,
   output logic [IDX_W-1:0]          idx
);

   always_comb begin
      any = |req;
      idx = '0;
      for (int g = GROUPS - 1; g >= 0; g--) begin
         if (|req[g*GROUP_W +: GROUP_W]) begin
            for (int i = 0; i < GROUP_W; i++) begin
               if (req[g*GROUP_W + i]) idx = IDX_W'(BASE + g*GROUP_W + i);
            end
         end
      end
   end

endmodule

// File: rtl/eirq_ctrl.sv
module eirq_ctrl
   import eirq_pkg::*;
#(
   parameter int NUM_BANKS    = 4,
   parameter int BANK_LINES   = 8,
   parameter int DIRECT_LINES = 16,
   parameter int SYNC_STAGES  = 2,
   parameter int ADDR_W       = 4,
   parameter int DATA_W       = 32,
   localparam int NUM_LINES   = NUM_BANKS * BANK_LINES,
   localparam int IDX_W       = $clog2(NUM_LINES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_LINES-1:0]    pins,
   input  logic                    bus_we,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_rdata,
   output logic [DIRECT_LINES-1:0] irq_direct,
   output logic                    irq_shared,
   output logic [IDX_W-1:0]        shared_line
);

   localparam int SHARED_LINES = NUM_LINES - DIRECT_LINES;
   localparam int BANK_AW      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

   generate
      if (ADDR_W != BANK_AW + 2) begin : g_bad_addr
         $error("eirq_ctrl: ADDR_W must equal bank bits plus 2");
      end
      if (DATA_W < BANK_LINES * FIELD_W) begin : g_bad_data
         $error("eirq_ctrl: DATA_W too narrow for a bank type word");
      end
      if ((DIRECT_LINES % BANK_LINES) != 0 || DIRECT_LINES > NUM_LINES) begin : g_bad_direct
         $error("eirq_ctrl: DIRECT_LINES must be whole banks within range");
      end
   endgenerate

   logic [1:0]                    sel;
   logic [BANK_AW-1:0]            bank_sel;
   logic                          wr_type;
   logic                          wr_mask;
   logic                          wr_pend;
   logic [NUM_LINES-1:0]          pend_q;
   logic [NUM_LINES-1:0]          mask_q;
   logic [NUM_LINES-1:0][TRIG_W-1:0] trig_q;
   logic [NUM_LINES-1:0]          active;

   assign sel      = bus_addr[1:0];
   assign bank_sel = bus_addr[ADDR_W-1:2];
   assign wr_type  = bus_we && (sel == SEL_TYPE);
   assign wr_mask  = bus_we && (sel == SEL_MASK);
   assign wr_pend  = bus_we && (sel == SEL_PEND);

   generate
      for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
         localparam int B = k / BANK_LINES;
         localparam int J = k % BANK_LINES;
         logic              hit;
         logic              clr;
         logic [TRIG_W-1:0] trig_r;
         logic              mask_r;

         assign hit = (int'(bank_sel) == B);
         assign clr = wr_pend && hit && bus_wdata[J];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               trig_r <= '0;
               mask_r <= 1'b1;
            end else begin
               if (wr_type && hit) trig_r <= bus_wdata[J*FIELD_W +: TRIG_W];
               if (wr_mask && hit) mask_r <= bus_wdata[J];
            end
         end

         assign trig_q[k] = trig_r;
         assign mask_q[k] = mask_r;

         eirq_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pins[k]),
            .trig (trig_r),
            .clr  (clr),
            .pend (pend_q[k])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (int'(bank_sel) == b) begin
            for (int j = 0; j < BANK_LINES; j++) begin
               case (sel)
                  SEL_TYPE: bus_rdata[j*FIELD_W +: TRIG_W] = trig_q[b*BANK_LINES + j];
                  SEL_MASK: bus_rdata[j] = mask_q[b*BANK_LINES + j];
                  SEL_PEND: bus_rdata[j] = pend_q[b*BANK_LINES + j];
                  default:  ;
               endcase
            end
         end
      end
   end

   assign active     = pend_q & ~mask_q;
   assign irq_direct = active[DIRECT_LINES-1:0];

   generate
      if (SHARED_LINES > 0) begin : g_shared
         eirq_pick #(
            .GROUPS (SHARED_LINES / BANK_LINES),
            .GROUP_W(BANK_LINES),
            .BASE   (DIRECT_LINES),
            .IDX_W  (IDX_W)
         ) u_pick (
            .req(active[NUM_LINES-1:DIRECT_LINES]),
            .any(irq_shared),
            .idx(shared_line)
         );
      end else begin : g_noshared
         assign irq_shared  = 1'b0;
         assign shared_line = '0;
      end
   endgenerate

endmodule

// File: rtl/eirq_ctrl_chk.sv
module eirq_ctrl_chk #(
   parameter int NUM_LINES    = 32,
   parameter int DIRECT_LINES = 16,
   parameter int BANK_LINES   = 8,
   parameter int ADDR_W       = 4,
   parameter int DATA_W       = 32,
   parameter int IDX_W        = 5
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    bus_we,
   input logic [ADDR_W-1:0]       bus_addr,
   input logic [DATA_W-1:0]       bus_wdata,
   input logic [DIRECT_LINES-1:0] irq_direct,
   input logic                    irq_shared,
   input logic [IDX_W-1:0]        shared_line,
   input logic [NUM_LINES-1:0]    pend,
   input logic [NUM_LINES-1:0]    mask
);

   localparam int SHARED_LINES = NUM_LINES - DIRECT_LINES;

   generate
      for (genvar k = 0; k < NUM_LINES; k++) begin : g_hold
         logic clr_k;
         assign clr_k = bus_we && (bus_addr[1:0] == 2'd2) &&
                        (int'(bus_addr[ADDR_W-1:2]) == k / BANK_LINES) &&
                        bus_wdata[k % BANK_LINES];
         assert_pend_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[k] && !clr_k) |=> pend[k]);
      end
   endgenerate

   assert_direct_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_direct & mask[DIRECT_LINES-1:0]) == '0);

   generate
      if (SHARED_LINES > 0) begin : g_sh
         assert_shared_any_R9: assert property (@(posedge clk) disable iff (!rst_n)
            irq_shared == (|(pend[NUM_LINES-1:DIRECT_LINES] & ~mask[NUM_LINES-1:DIRECT_LINES])));

         assert_idx_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
            irq_shared |-> (int'(shared_line) >= DIRECT_LINES) &&
                           pend[shared_line] && !mask[shared_line]);

         assert_idx_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_shared |-> (shared_line == '0));

         if (SHARED_LINES > BANK_LINES) begin : g_order
            assert_bank_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
               (irq_shared && int'(shared_line) >= DIRECT_LINES + BANK_LINES) |->
               ((pend[DIRECT_LINES +: BANK_LINES] & ~mask[DIRECT_LINES +: BANK_LINES]) == '0));
         end
      end
   endgenerate

endmodule

bind eirq_ctrl eirq_ctrl_chk #(
   .NUM_LINES   (NUM_LINES),
   .DIRECT_LINES(DIRECT_LINES),
   .BANK_LINES  (BANK_LINES),
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .IDX_W       (IDX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_we     (bus_we),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .irq_direct (irq_direct),
   .irq_shared (irq_shared),
   .shared_line(shared_line),
   .pend       (pend_q),
   .mask       (mask_q)
);

// File: tb/sim_eirq_ctrl.sv
module sim_eirq_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pins = '0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] irq_direct;
   logic        irq_shared;
   logic [4:0]  shared_line;

   int n_chk = 0;
   int n_err = 0;
   bit mon_en = 1'b0;
   bit done = 1'b0;

   always #4ns clk = ~clk;

   eirq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .pins(pins), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_direct(irq_direct), .irq_shared(irq_shared), .shared_line(shared_line)
   );

   // reference model, built from the requirements
   logic [31:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_pend = '0, m_mask = '1;
   logic [2:0]  m_trig [32];
   logic [31:0] m_set, m_clr;

   function automatic logic set_fn(logic [2:0] t, logic s, logic p);
      case (t)
         3'd0: return !s;
         3'd1: return s;
         3'd2: return p & !s;
         3'd3: return !p & s;
         3'd4: return p ^ s;
         default: return 1'b0;
      endcase
   endfunction

   initial for (int k = 0; k < 32; k++) m_trig[k] = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0; m_mask = '1;
         for (int k = 0; k < 32; k++) m_trig[k] = '0;
      end else begin
         for (int k = 0; k < 32; k++) begin
            m_set[k] = set_fn(m_trig[k], m_s2[k], m_prev[k]);
            m_clr[k] = bus_we && bus_addr[1:0] == 2'd2 &&
                       int'(bus_addr[3:2]) == k / 8 && bus_wdata[k % 8];
         end
         m_pend = m_set | (m_pend & ~m_clr);
         m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
         if (bus_we) begin
            for (int j = 0; j < 8; j++) begin
               if (bus_addr[1:0] == 2'd0) m_trig[bus_addr[3:2]*8 + j] = bus_wdata[j*4 +: 3];
               if (bus_addr[1:0] == 2'd1) m_mask[bus_addr[3:2]*8 + j] = bus_wdata[j];
            end
         end
      end
   end

   function automatic logic [31:0] exp_read(logic [3:0] a);
      logic [31:0] r = '0;
      for (int j = 0; j < 8; j++) begin
         case (a[1:0])
            2'd0: r[j*4 +: 3] = m_trig[a[3:2]*8 + j];
            2'd1: r[j] = m_mask[a[3:2]*8 + j];
            2'd2: r[j] = m_pend[a[3:2]*8 + j];
            default: ;
         endcase
      end
      return r;
   endfunction

   function automatic logic [4:0] exp_idx();
      logic [31:0] act = m_pend & ~m_mask;
      logic [4:0]  ix = '0;
      for (int g = 3; g >= 2; g--)
         if (|act[g*8 +: 8])
            for (int i = 0; i < 8; i++) if (act[g*8 + i]) ix = 5'(g*8 + i);
      return ix;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (mon_en) begin
         #2ns;
         chk("R8 direct vs model", 32'(irq_direct), 32'(m_pend[15:0] & ~m_mask[15:0]));
         chk("R9 shared vs model", 32'(irq_shared), 32'(|(m_pend[31:16] & ~m_mask[31:16])));
         chk("R10 index vs model", 32'(shared_line), 32'(exp_idx()));
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a;
      #1ns;
      d = bus_rdata;
   endtask

   function automatic logic [3:0] ra(int b, int s);
      return {2'(b), 2'(s)};
   endfunction

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #1ms;
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      logic [31:0] v;
      int unused_seed;
      unused_seed = $urandom(32'h1d2c);

      // R1: reset values, read during reset
      step(2);
      for (int b = 0; b < 4; b++) begin
         rd(ra(b, 1), v); chk("R1 mask reset", v, 32'h0000_00ff);
         rd(ra(b, 0), v); chk("R1 type reset", v, 32'h0);
         rd(ra(b, 2), v); chk("R1 pend reset", v, 32'h0);
      end
      chk("R1 outputs reset", {irq_direct, 11'd0, irq_shared, shared_line}, 32'h0);
      @(negedge clk); rst_n = 1'b1;
      mon_en = 1'b1;

      // R7: low-level default with pins low latches pending while masked
      step(4);
      rd(ra(0, 2), v); chk("R7 masked pend latches bank0", v, 32'h0000_00ff);
      rd(ra(3, 2), v); chk("R7 masked pend latches bank3", v, 32'h0000_00ff);
      chk("R7 masked outputs quiet", 32'(irq_direct), 32'h0);

      for (int b = 0; b < 4; b++) wr(ra(b, 0), 32'h3333_3333);
      for (int b = 0; b < 4; b++) wr(ra(b, 2), 32'hffff_ffff);
      rd(ra(2, 2), v); chk("R5 write-one clears", v, 32'h0);

      // R2: field layout
      rd(ra(1, 0), v); chk("R2 type readback", v, 32'h3333_3333);
      wr(ra(2, 0), 32'hffff_ffff);
      rd(ra(2, 0), v); chk("R2 spare nibble bit reads 0", v, 32'h7777_7777);
      wr(ra(2, 1), 32'hffff_ff00);
      rd(ra(2, 1), v); chk("R2 mask upper bits ignored", v, 32'h0);
      rd(ra(2, 3), v); chk("R2 sel 3 reads 0", v, 32'h0);
      wr(ra(2, 0), 32'h3333_3333);
      for (int b = 0; b < 4; b++) wr(ra(b, 1), 32'h0);

      // R4: rising edge on line 3, latency of three edges
      pins[3] = 1'b1;
      step(2); chk("R4 rise not yet", 32'(irq_direct), 32'h0);
      step(1); chk("R4 rise latched", 32'(irq_direct), 32'h0008);
      pins[3] = 1'b0;
      step(4); chk("R4 edge holds after pin drops", 32'(irq_direct), 32'h0008);
      wr(ra(0, 2), 32'h0);
      rd(ra(0, 2), v); chk("R5 write zero leaves", v, 32'h08);
      wr(ra(0, 2), 32'h08);
      chk("R5 ack clears line 3", 32'(irq_direct), 32'h0);

      // line 5 high level, 6 falling, 7 both edges
      wr(ra(0, 0), 32'h4213_3333);
      pins[6] = 1'b1; step(4);
      chk("R4 falling ignores rise", 32'(irq_direct), 32'h0);
      pins[6] = 1'b0; step(3);
      chk("R4 falling latched", 32'(irq_direct), 32'h0040);
      wr(ra(0, 2), 32'h40);
      pins[7] = 1'b1; step(3);
      chk("R4 both-edge rise", 32'(irq_direct), 32'h0080);
      wr(ra(0, 2), 32'h80);
      pins[7] = 1'b0; step(3);
      chk("R4 both-edge fall", 32'(irq_direct), 32'h0080);
      wr(ra(0, 2), 32'h80);
      pins[5] = 1'b1; step(3);
      chk("R3 high level pending", 32'(irq_direct), 32'h0020);
      wr(ra(0, 2), 32'h20);
      chk("R6 set beats clear on live level", 32'(irq_direct), 32'h0020);
      pins[5] = 1'b0; step(3);
      wr(ra(0, 2), 32'h20);
      chk("R3 level gone then cleared", 32'(irq_direct), 32'h0);

      // R3 low level on line 8, R4 disabled type 5 on line 9
      wr(ra(1, 0), 32'h3333_3350);
      step(4); chk("R3 low level pending", 32'(irq_direct), 32'h0100);
      pins[8] = 1'b1; step(3);
      wr(ra(1, 2), 32'h01);
      pins[9] = 1'b1; step(3); pins[9] = 1'b0; step(3);
      rd(ra(1, 2), v); chk("R4 type 5 never pends", v, 32'h0);
      chk("R3 low level released", 32'(irq_direct), 32'h0);

      // R9/R10 shared output ordering
      pins[20] = 1'b1; pins[30] = 1'b1; step(3);
      chk("R9 shared raised", 32'(irq_shared), 32'h1);
      chk("R10 lower bank first", 32'(shared_line), 32'd20);
      pins[22] = 1'b1; step(3);
      chk("R10 highest in bank", 32'(shared_line), 32'd22);
      wr(ra(2, 2), 32'h50);
      chk("R10 falls to upper bank", 32'(shared_line), 32'd30);
      wr(ra(3, 1), 32'hff);
      chk("R9 masked shared low", 32'(irq_shared), 32'h0);
      chk("R10 idle index zero", 32'(shared_line), 32'h0);
      rd(ra(3, 2), v); chk("R7 masked upper still pending", v, 32'h40);
      wr(ra(3, 1), 32'h0);
      wr(ra(3, 2), 32'hff);

      // random phase against the model
      for (int c = 0; c < 3000; c++) begin
         @(negedge clk);
         pins = $urandom;
         bus_we = ($urandom % 4) == 0;
         bus_addr = 4'($urandom);
         bus_wdata = $urandom;
         #1ns;
         chk("R2 random readback", bus_rdata, exp_read(bus_addr));
      end
      @(negedge clk);
      bus_we = 1'b0;
      step(2);
      mon_en = 1'b0;
      done = 1'b1;
      finish_run();
   end

endmodule